// File: doc/BRIEF.md
# I2C Byte-Level Slave Controller

This block is the slave side of an I2C link, seen by a host processor as four byte-wide registers. It samples the SCL and SDA wires through synchronising glitch filters and detects START and STOP conditions on them. It shifts in the address byte and compares it with a programmable 7-bit own address and, if enabled, with the general call address. Every byte-level event of interest is reported as an 8-bit status code together with an interrupt flag.

While the interrupt flag is up, the block holds SCL low from its next falling edge, so the bus master waits until the host has read or loaded the data register and cleared the flag. An acknowledge-enable bit chooses between ACK and NACK for incoming bytes. With that bit low, the block stops answering its addresses but keeps following bus traffic. The block needs no knowledge of the SCL rate; it follows any clock whose high and low phases are well above the filter delay.

Top module: `i2cs_slave`

## Requirements
- R1: The interrupt flag is raised each time the status takes any code other than F8h (own address + write ACKed 60h, general call ACKed 70h, data received ACK 80h / NACK 88h, STOP or repeated START while addressed A0h, own address + read ACKed A8h, byte sent and ACK received B8h, byte sent and NACK received C0h, last byte sent and ACK received C8h). A cleared flag returns the status to F8h, and the flag is never high while the status is F8h.
- R2: While the flag is high, SCL is pulled low from its next falling edge until the flag is cleared. SCL is never pulled low by the block while it is high.
- R3: Register map: offset 0 control (bit 0 acknowledge enable, read/write; bit 1 reads the flag, and writing 1 clears it), offset 1 status (read only), offset 2 data, offset 3 own address (bits 7:1 address, bit 0 general-call enable). Only a control write with bit 1 set clears the flag.
- R4: With acknowledge enable at 1, a matching own address is ACKed with status 60h (R/W bit 0) or A8h (R/W bit 1). An all-zero address byte is ACKed with status 70h when general call is enabled.
- R5: With general call disabled, an all-zero address byte gets a NACK and leaves the flag low and the status at F8h.
- R6: A data byte received while addressed is stored in the data register. It is ACKed with status 80h if acknowledge enable is 1. Otherwise it is NACKed with status 88h, and once the flag is cleared the block is not addressed, so further bytes get no ACK and no flag.
- R7: As transmitter, the block sends the data register MSB first. Status is B8h when the master ACKs, C0h when it NACKs, and C8h when it ACKs a byte loaded while acknowledge enable was 0. After clearing C0h or C8h, SDA stays released (the master reads FFh).
- R8: With acknowledge enable at 0, the own address gets no ACK and no flag. START detection continues, so a repeated START after re-enabling is answered.
- R9: Acknowledge enable set part-way through an address byte takes effect for that byte.
- R10: A STOP or a repeated START while addressed sets status A0h and the flag.
- R11: Transfers complete correctly at different SCL rates with no rate setting.
- R12: After reset the status is F8h, the flag is low and neither line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Level sensed on the SCL wire |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_in | input | 1 | Level sensed on the SDA wire |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data for reg_addr |
| irq | output | 1 | Interrupt flag |

## Verification
The hardest states to reach are those that depend on host action landing between bus clocks. Examples are acknowledge enable changing halfway through an address byte, a repeated START issued while the block is addressed, and the C8h last-byte path, which needs the enable to drop before the transmit byte is loaded. The bench drives the bus as a bit-level master that waits on the wired-AND SCL. It interleaves host register writes between individual bits or bytes to reach these states, and mixes in randomly chosen reads and writes at two SCL rates.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_W = 8;
    localparam int BITCNT_W = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_RXD, ST_TXD, ST_ACKO, ST_ACKI, ST_WAIT
    } eng_state_t;

    typedef enum logic [1:0] {
        NX_IDLE, NX_RX, NX_TX
    } next_act_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_evt_t;

    typedef struct packed {
        logic [6:0] own_addr;
        logic       gc_en;
        logic       ack_en;
    } host_cfg_t;

    localparam logic [7:0] CODE_NONE    = 8'hF8;
    localparam logic [7:0] CODE_SLA_W   = 8'h60;
    localparam logic [7:0] CODE_GCALL   = 8'h70;
    localparam logic [7:0] CODE_RX_ACK  = 8'h80;
    localparam logic [7:0] CODE_RX_NACK = 8'h88;
    localparam logic [7:0] CODE_BREAK   = 8'hA0;
    localparam logic [7:0] CODE_SLA_R   = 8'hA8;
    localparam logic [7:0] CODE_TX_ACK  = 8'hB8;
    localparam logic [7:0] CODE_TX_NACK = 8'hC0;
    localparam logic [7:0] CODE_TX_LAST = 8'hC8;

    localparam logic [1:0] OFF_CTRL = 2'd0;
    localparam logic [1:0] OFF_STAT = 2'd1;
    localparam logic [1:0] OFF_DATA = 2'd2;
    localparam logic [1:0] OFF_SADR = 2'd3;
    localparam int CTRL_ACK_BIT = 0;
    localparam int CTRL_IRQ_BIT = 1;

    function automatic logic own_hit(logic [7:0] rx, logic [6:0] own);
        return rx[7:1] == own;
    endfunction

    function automatic logic gcall_hit(logic [7:0] rx, logic en);
        return en && (rx == 8'h00);
    endfunction

endpackage

// File: rtl/i2cs_glitch_filt.sv
module i2cs_glitch_filt #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            cnt_q  <= '0;
            out_q  <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            if (sync_q[SYNC_STAGES-1] != out_q) begin
                if (cnt_q == CW'(FILT_LEN - 1)) begin
                    out_q <= sync_q[SYNC_STAGES-1];
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                cnt_q <= '0;
            end
        end
    end

    assign line_o = out_q;

endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
    import i2cs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [1:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic [7:0]  status,
    input  logic        irq,
    input  logic        rx_load,
    input  logic [7:0]  rx_byte,
    output host_cfg_t   cfg,
    output logic [7:0]  tx_byte,
    output logic        irq_clr
);
    host_cfg_t  cfg_q;
    logic [7:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            data_q <= '0;
        end else begin
            if (we && addr == OFF_CTRL) cfg_q.ack_en <= wdata[CTRL_ACK_BIT];
            if (we && addr == OFF_SADR) begin
                cfg_q.own_addr <= wdata[7:1];
                cfg_q.gc_en    <= wdata[0];
            end
            if (rx_load)                     data_q <= rx_byte;
            else if (we && addr == OFF_DATA) data_q <= wdata;
        end
    end

    always_comb begin
        unique case (addr)
            OFF_CTRL: rdata = {6'b0, irq, cfg_q.ack_en};
            OFF_STAT: rdata = status;
            OFF_DATA: rdata = data_q;
            default:  rdata = {cfg_q.own_addr, cfg_q.gc_en};
        endcase
    end

    assign cfg     = cfg_q;
    assign tx_byte = data_q;
    assign irq_clr = we && (addr == OFF_CTRL) && wdata[CTRL_IRQ_BIT];

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_f,
    input  logic       sda_f,
    input  host_cfg_t  cfg,
    input  logic       irq_clr,
    input  logic [7:0] tx_byte,
    output logic       rx_load,
    output logic [7:0] rx_byte,
    output logic [7:0] status,
    output logic       irq,
    output logic       scl_hold,
    output logic       sda_drive
);
    eng_state_t          state_q;
    next_act_t           next_q;
    logic [BITCNT_W-1:0] bitcnt_q;
    logic [7:0]          shreg_q, status_q, pend_q;
    logic                irq_q, hold_q, drive_q, addressed_q;
    logic                tx_last_q, ack_bit_q, rx_load_q;
    logic                scl_q, sda_q;
    bus_evt_t            evt;
    logic                hit_own, hit_gc;

    always_comb begin
        evt.start = scl_f && scl_q && sda_q && !sda_f;
        evt.stop  = scl_f && scl_q && !sda_q && sda_f;
        evt.rise  = scl_f && !scl_q;
        evt.fall  = !scl_f && scl_q;
        hit_own   = own_hit(shreg_q, cfg.own_addr);
        hit_gc    = gcall_hit(shreg_q, cfg.gc_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            next_q      <= NX_IDLE;
            bitcnt_q    <= '0;
            shreg_q     <= '0;
            status_q    <= CODE_NONE;
            pend_q      <= CODE_NONE;
            irq_q       <= 1'b0;
            hold_q      <= 1'b0;
            drive_q     <= 1'b0;
            addressed_q <= 1'b0;
            tx_last_q   <= 1'b0;
            ack_bit_q   <= 1'b1;
            rx_load_q   <= 1'b0;
            scl_q       <= 1'b1;
            sda_q       <= 1'b1;
        end else begin
            scl_q     <= scl_f;
            sda_q     <= sda_f;
            rx_load_q <= 1'b0;
            if (evt.start || evt.stop) begin
                if (addressed_q) begin
                    status_q <= CODE_BREAK;
                    irq_q    <= 1'b1;
                end
                state_q     <= evt.start ? ST_ADDR : ST_IDLE;
                bitcnt_q    <= '0;
                drive_q     <= 1'b0;
                addressed_q <= 1'b0;
            end else if (irq_clr && irq_q) begin
                irq_q    <= 1'b0;
                hold_q   <= 1'b0;
                status_q <= CODE_NONE;
                if (state_q == ST_WAIT) begin
                    bitcnt_q <= '0;
                    unique case (next_q)
                        NX_RX: state_q <= ST_RXD;
                        NX_TX: begin
                            state_q   <= ST_TXD;
                            shreg_q   <= tx_byte;
                            drive_q   <= ~tx_byte[7];
                            tx_last_q <= ~cfg.ack_en;
                        end
                        default: begin
                            state_q     <= ST_IDLE;
                            addressed_q <= 1'b0;
                        end
                    endcase
                end
            end else if (evt.rise) begin
                unique case (state_q)
                    ST_IDLE, ST_ADDR, ST_RXD: begin
                        shreg_q  <= {shreg_q[6:0], sda_f};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                    ST_TXD:  bitcnt_q  <= bitcnt_q + 1'b1;
                    ST_ACKI: ack_bit_q <= sda_f;
                    default: ;
                endcase
            end else if (evt.fall) begin
                if (irq_q) hold_q <= 1'b1;
                unique case (state_q)
                    ST_ADDR: if (bitcnt_q == BITCNT_W'(BYTE_W)) begin
                        if (cfg.ack_en && (hit_own || hit_gc)) begin
                            drive_q     <= 1'b1;
                            addressed_q <= 1'b1;
                            state_q     <= ST_ACKO;
                            pend_q      <= hit_own ? (shreg_q[0] ? CODE_SLA_R : CODE_SLA_W)
                                                   : CODE_GCALL;
                            next_q      <= (hit_own && shreg_q[0]) ? NX_TX : NX_RX;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                    ST_RXD: if (bitcnt_q == BITCNT_W'(BYTE_W)) begin
                        rx_load_q <= 1'b1;
                        drive_q   <= cfg.ack_en;
                        pend_q    <= cfg.ack_en ? CODE_RX_ACK : CODE_RX_NACK;
                        next_q    <= cfg.ack_en ? NX_RX : NX_IDLE;
                        state_q   <= ST_ACKO;
                    end
                    ST_ACKO: begin
                        drive_q  <= 1'b0;
                        status_q <= pend_q;
                        irq_q    <= 1'b1;
                        hold_q   <= 1'b1;
                        state_q  <= ST_WAIT;
                    end
                    ST_TXD: if (bitcnt_q == BITCNT_W'(BYTE_W)) begin
                        drive_q <= 1'b0;
                        state_q <= ST_ACKI;
                    end else begin
                        shreg_q <= {shreg_q[6:0], 1'b0};
                        drive_q <= ~shreg_q[6];
                    end
                    ST_ACKI: begin
                        status_q <= ack_bit_q ? CODE_TX_NACK
                                              : (tx_last_q ? CODE_TX_LAST : CODE_TX_ACK);
                        next_q   <= (ack_bit_q || tx_last_q) ? NX_IDLE : NX_TX;
                        irq_q    <= 1'b1;
                        hold_q   <= 1'b1;
                        state_q  <= ST_WAIT;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign rx_load   = rx_load_q;
    assign rx_byte   = shreg_q;
    assign status    = status_q;
    assign irq       = irq_q;
    assign scl_hold  = hold_q;
    assign sda_drive = drive_q;

    assert_f8_no_irq_R1: assert property (@(posedge clk) disable iff (rst)
        (status_q == CODE_NONE) |-> !irq_q);

    assert_hold_only_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_q) |-> !scl_f);

    assert_flag_host_clear_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_q) |-> $past(irq_clr));

    assert_sda_moves_low_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_q) |-> !scl_f);

    assert_idle_released_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |-> !drive_q);

endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    output logic       scl_oe,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines, filt_lines;
    host_cfg_t  cfg;
    logic       irq_clr, rx_load;
    logic [7:0] rx_byte, tx_byte, status;

    assign raw_lines = {sda_in, scl_in};

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_filt
        i2cs_glitch_filt #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) filt_i (
            .clk   (clk),
            .rst   (rst),
            .line_i(raw_lines[gi]),
            .line_o(filt_lines[gi])
        );
    end

    i2cs_regs regs_i (
        .clk    (clk),
        .rst    (rst),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .status (status),
        .irq    (irq),
        .rx_load(rx_load),
        .rx_byte(rx_byte),
        .cfg    (cfg),
        .tx_byte(tx_byte),
        .irq_clr(irq_clr)
    );

    i2cs_engine engine_i (
        .clk      (clk),
        .rst      (rst),
        .scl_f    (filt_lines[0]),
        .sda_f    (filt_lines[1]),
        .cfg      (cfg),
        .irq_clr  (irq_clr),
        .tx_byte  (tx_byte),
        .rx_load  (rx_load),
        .rx_byte  (rx_byte),
        .status   (status),
        .irq      (irq),
        .scl_hold (scl_oe),
        .sda_drive(sda_oe)
    );

endmodule

// File: tb/i2cs_slave_tb_top.sv
`timescale 1ns/1ps
module i2cs_slave_tb_top;

    localparam logic [6:0] OWN = 7'h5A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq, scl_oe, sda_oe;
    logic       scl_w, sda_w;

    int  hp = 24;
    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  ack_tb = 1'b0;

    always #10 clk = ~clk;

    assign scl_w = m_scl & ~scl_oe;
    assign sda_w = m_sda & ~sda_oe;

    i2cs_slave dut_i (
        .clk(clk), .rst(rst),
        .scl_in(scl_w), .scl_oe(scl_oe),
        .sda_in(sda_w), .sda_oe(sda_oe),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [7:0] exp_rx_code(bit a);
        return a ? 8'h80 : 8'h88;
    endfunction

    function automatic logic [7:0] exp_tx_code(bit m_nack, bit last);
        if (m_nack) return 8'hC0;
        return last ? 8'hC8 : 8'hB8;
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_ack(bit v);
        ack_tb = v;
        wr(2'd0, {6'b0, 1'b0, v});
    endtask

    task automatic host_clear();
        wr(2'd0, {6'b0, 1'b1, ack_tb});
    endtask

    task automatic expect_evt(string tag, bit irq_e, logic [7:0] code_e);
        logic [7:0] st;
        rd(2'd1, st);
        chk({tag, " irq"}, int'(irq), int'(irq_e));
        chk({tag, " status"}, int'(st), int'(code_e));
    endtask

    task automatic wait_scl_high();
        while (!scl_w) @(negedge clk);
    endtask

    task automatic bit_out(bit b);
        m_sda = b; tick(hp / 2);
        m_scl = 1'b1; wait_scl_high(); tick(hp);
        m_scl = 1'b0; tick(hp / 2);
    endtask

    task automatic bit_in(output bit b);
        m_sda = 1'b1; tick(hp / 2);
        m_scl = 1'b1; wait_scl_high(); tick(hp / 2);
        b = sda_w; tick(hp / 2);
        m_scl = 1'b0; tick(hp / 2);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(hp / 2);
        m_scl = 1'b1; wait_scl_high(); tick(hp / 2);
        m_sda = 1'b0; tick(hp / 2);
        m_scl = 1'b0; tick(hp / 2);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(hp / 2);
        m_scl = 1'b1; wait_scl_high(); tick(hp / 2);
        m_sda = 1'b1; tick(hp);
    endtask

    task automatic send_byte(logic [7:0] b, output bit acked);
        bit nb;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(nb);
        acked = !nb;
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit m_ack);
        bit x;
        for (int i = 7; i >= 0; i--) begin
            bit_in(x);
            b[i] = x;
        end
        bit_out(!m_ack);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, d, b;
        bit a;
        int unsigned seed;
        seed = $urandom(32'd9173);

        tick(6);
        rst = 1'b0;
        tick(4);
        // R12 reset state
        rd(2'd1, v);
        chk("R12 status", v, 8'hF8);
        chk("R12 irq", irq, 0);
        chk("R12 scl_oe", scl_oe, 0);
        chk("R12 sda_oe", sda_oe, 0);

        wr(2'd3, {OWN, 1'b1});
        set_ack(1'b1);

        // write transfer, R4 R2 R3 R1 R6
        bus_start();
        send_byte({OWN, 1'b0}, a);
        chk("R4 own write ack", a, 1);
        expect_evt("R1 R4 60", 1'b1, 8'h60);
        m_scl = 1'b1; tick(30);
        chk("R2 stretch wire", scl_w, 0);
        chk("R2 scl_oe", scl_oe, 1);
        m_scl = 1'b0; tick(2);
        wr(2'd0, 8'h01);
        tick(20);
        chk("R3 flag kept", irq, 1);
        host_clear();
        expect_evt("R1 cleared", 1'b0, 8'hF8);
        chk("R2 released", scl_oe, 0);

        d = 8'($urandom);
        send_byte(d, a);
        chk("R6 data ack", a, 1);
        expect_evt("R6 80", 1'b1, exp_rx_code(1'b1));
        rd(2'd2, v);
        chk("R6 data reg", v, d);
        host_clear();
        set_ack(1'b0);
        d = 8'($urandom);
        send_byte(d, a);
        chk("R6 data nack", a, 0);
        expect_evt("R6 88", 1'b1, exp_rx_code(1'b0));
        rd(2'd2, v);
        chk("R6 data reg nack", v, d);
        host_clear();
        send_byte(8'h3C, a);
        chk("R6 unaddressed nack", a, 0);
        expect_evt("R6 unaddressed", 1'b0, 8'hF8);
        bus_stop();
        tick(10);
        chk("R10 no break when unaddressed", irq, 0);

        // general call R4 R10 R2
        set_ack(1'b1);
        bus_start();
        send_byte(8'h00, a);
        chk("R4 gc ack", a, 1);
        expect_evt("R4 70", 1'b1, 8'h70);
        host_clear();
        send_byte(8'hA5, a);
        expect_evt("R6 gc data", 1'b1, 8'h80);
        host_clear();
        bus_stop();
        tick(10);
        expect_evt("R10 stop A0", 1'b1, 8'hA0);
        chk("R2 no pull while high", scl_oe, 0);
        chk("R2 wire high", scl_w, 1);
        host_clear();

        // R5 gc disabled
        wr(2'd3, {OWN, 1'b0});
        bus_start();
        send_byte(8'h00, a);
        chk("R5 gc nack", a, 0);
        expect_evt("R5 no flag", 1'b0, 8'hF8);
        bus_stop();
        wr(2'd3, {OWN, 1'b1});

        // R7 transmitter: B8 then C8 then released
        bus_start();
        send_byte({OWN, 1'b1}, a);
        chk("R4 own read ack", a, 1);
        expect_evt("R4 A8", 1'b1, 8'hA8);
        d = 8'($urandom);
        wr(2'd2, d);
        host_clear();
        recv_byte(b, 1'b1);
        chk("R7 tx byte", b, d);
        expect_evt("R7 B8", 1'b1, exp_tx_code(1'b0, 1'b0));
        d = 8'($urandom);
        wr(2'd2, d);
        set_ack(1'b0);
        host_clear();
        recv_byte(b, 1'b1);
        chk("R7 tx last byte", b, d);
        expect_evt("R7 C8", 1'b1, exp_tx_code(1'b0, 1'b1));
        host_clear();
        recv_byte(b, 1'b0);
        chk("R7 released after C8", b, 8'hFF);
        bus_stop();
        tick(10);
        chk("R7 no flag after C8", irq, 0);

        // R7 master NACK
        set_ack(1'b1);
        bus_start();
        send_byte({OWN, 1'b1}, a);
        wr(2'd2, 8'h96);
        host_clear();
        recv_byte(b, 1'b0);
        chk("R7 tx nack byte", b, 8'h96);
        expect_evt("R7 C0", 1'b1, exp_tx_code(1'b1, 1'b0));
        host_clear();
        bus_stop();
        tick(10);
        chk("R7 no flag after C0", irq, 0);

        // R8 ignored address, repeated START still seen; R10 repeated START
        set_ack(1'b0);
        bus_start();
        send_byte({OWN, 1'b0}, a);
        chk("R8 own nack", a, 0);
        expect_evt("R8 no flag", 1'b0, 8'hF8);
        set_ack(1'b1);
        bus_start();
        send_byte({OWN, 1'b0}, a);
        chk("R8 after restart ack", a, 1);
        expect_evt("R8 60", 1'b1, 8'h60);
        host_clear();
        bus_start();
        expect_evt("R10 restart A0", 1'b1, 8'hA0);
        host_clear();
        send_byte({OWN, 1'b0}, a);
        chk("R10 readdress ack", a, 1);
        host_clear();
        bus_stop();
        tick(10);
        expect_evt("R10 stop A0 b", 1'b1, 8'hA0);
        host_clear();

        // R9 enable mid address
        set_ack(1'b0);
        bus_start();
        for (int i = 7; i >= 4; i--) bit_out(OWN[i-1]);
        set_ack(1'b1);
        for (int i = 3; i >= 1; i--) bit_out(OWN[i-1]);
        bit_out(1'b0);
        bit_in(a);
        chk("R9 late enable ack", a, 0);
        expect_evt("R9 60", 1'b1, 8'h60);
        host_clear();
        bus_stop();
        tick(10);
        host_clear();

        // R11 random transfers at two rates
        for (int r = 0; r < 6; r++) begin
            bit rdm;
            int n;
            hp = (r % 2) ? 60 : 24;
            rdm = 1'($urandom % 2);
            n = 1 + int'($urandom % 3);
            bus_start();
            send_byte({OWN, rdm}, a);
            chk("R11 addr ack", a, 1);
            expect_evt("R11 addr", 1'b1, rdm ? 8'hA8 : 8'h60);
            if (!rdm) begin
                host_clear();
                for (int k = 0; k < n; k++) begin
                    d = 8'($urandom);
                    send_byte(d, a);
                    chk("R11 rx ack", a, 1);
                    rd(2'd2, v);
                    chk("R11 rx data", v, d);
                    expect_evt("R11 rx", 1'b1, exp_rx_code(1'b1));
                    host_clear();
                end
                bus_stop();
                tick(10);
                expect_evt("R11 stop", 1'b1, 8'hA0);
                host_clear();
            end else begin
                for (int k = 0; k < n; k++) begin
                    d = 8'($urandom);
                    wr(2'd2, d);
                    host_clear();
                    recv_byte(b, k != n - 1);
                    chk("R11 tx data", b, d);
                    expect_evt("R11 tx", 1'b1, exp_tx_code(k == n - 1, 1'b0));
                end
                host_clear();
                bus_stop();
                tick(10);
                chk("R11 tx end quiet", irq, 0);
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule